// File: doc/BRIEF.md
# Serial Configuration Write Port

The block receives a 16-bit configuration word over a three-wire serial link: an active-low select, a serial clock that idles high, and a data line. Pulling the select low opens a frame. Data is shifted in most significant bit first on each falling serial-clock edge. A frame counts only if all 16 bits arrive. The word is then committed on whichever comes first: the first rising serial-clock edge after the sixteenth falling edge, or the select returning high. If the select rises before sixteen bits have been shifted in, the frame is discarded and a short error pulse is raised.

The committed word drives two groups of outputs. The format, mode and bus-select flags follow the committed register at once, in the serial domain. The two 5-bit per-channel gain codes are handed to a separate conversion clock through a toggle flag and a synchronizer on that clock's falling edges. They appear on the second falling conversion-clock edge after the commit, so a gain code never changes in the middle of a sampling period.

Top module: `ctrl_serial_port`

## Requirements
- R1: While reset is asserted and after it is released, every output is 0: twos_o, mode_o, bus_sel_o, gain_a_o, gain_b_o and err_o.
- R2: Frame bits are taken on falling sclk_i edges while cs_ni is low, the first bit being word bit 15. The fields are: bit 13 drives twos_o, bit 12 drives mode_o, bit 11 drives bus_sel_o, bits 9:5 are the gain code of channel B and bits 4:0 are the gain code of channel A.
- R3: With cs_ni still low, the first rising sclk_i edge after the sixteenth falling edge commits the word. twos_o, mode_o and bus_sel_o take their new values at that same edge.
- R4: If cs_ni rises after sixteen falling edges and before any further rising sclk_i edge, the cs_ni rising edge commits the word, with the same immediate effect on the three flag outputs.
- R5: If cs_ni rises after fewer than sixteen falling edges (zero included), no output changes. err_o goes to 1 at that cs_ni rise and returns to 0 at the next rising sclk_i edge. The next frame starts counting from zero.
- R6: Falling edges after the sixteenth in one frame are ignored. Only the first sixteen bits are committed, and only once per frame.
- R7: gain_a_o and gain_b_o keep their old value through the first falling clk_i edge after a commit and show the new codes after the second falling clk_i edge.
- R8: Bits 15, 14 and 10 of the word are reserved and have no effect on any output.
- R9: After every commit, gain_a_o and gain_b_o settle to the gain fields of the committed word. The gain outputs change only on a falling clk_i edge at which they take the current committed codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock; gain outputs update on its falling edge |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| sclk_i | input | 1 | Serial clock, idles high |
| cs_ni | input | 1 | Active-low frame select |
| sdi_i | input | 1 | Serial data, MSB first |
| twos_o | output | 1 | Committed two's-complement format flag |
| mode_o | output | 1 | Committed mode flag |
| bus_sel_o | output | 1 | Committed bus-select flag |
| gain_a_o | output | GAIN_W | Channel A gain code, conversion domain |
| gain_b_o | output | GAIN_W | Channel B gain code, conversion domain |
| err_o | output | 1 | Incomplete-frame pulse |

## Verification
The flag outputs are due at the committing edge itself, either the sixteenth-bit rising sclk_i edge or the cs_ni rise, so the bench checks them one nanosecond after driving that edge. The gain codes are due on the second falling clk_i edge after the commit. In timed frames the bench samples one nanosecond after the first falling edge, where it expects the old codes, and again after the second, where it expects the new ones. In every other frame it waits several conversion cycles before it compares the gains. The error pulse is checked just after the aborting cs_ni rise and again just after the next rising sclk_i edge.

// File: rtl/csp_pkg.sv
package csp_pkg;
  localparam int CSP_WORD_W   = 16;
  localparam int CSP_GAIN_W   = 5;
  localparam int CSP_NUM_CH   = 2;
  localparam int CSP_TWOS_POS = 13;
  localparam int CSP_MODE_POS = 12;
  localparam int CSP_BUS_POS  = 11;
  localparam int CSP_RSV_POS  = 10;
  localparam int CSP_GB_LSB   = 5;
  localparam int CSP_GA_LSB   = 0;

  typedef struct packed {
    logic twos;
    logic mode;
    logic bus_sel;
  } csp_flags_t;
endpackage

// File: rtl/csp_shift.sv
module csp_shift #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              sdi_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [WORD_W-1:0] word_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shreg_q;

  // counter held clear while deselected; saturates at a full word
  always_ff @(negedge sclk_i or posedge cs_ni or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      shreg_q <= '0;
    end else if (cs_ni) begin
      cnt_q <= '0;
    end else if (cnt_q != FULL) begin
      shreg_q <= {shreg_q[WORD_W-2:0], sdi_i};
      cnt_q   <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o  = cnt_q;
  assign word_o = shreg_q;
endmodule

// File: rtl/csp_commit.sv
module csp_commit #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] cfg_o,
  output logic              upd_tog_o,
  output logic              err_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic              open_q, close_q;
  logic              done_q, err_q, upd_q;
  logic [WORD_W-1:0] cfg_q;

  always_ff @(negedge cs_ni or negedge rst_ni) begin
    if (!rst_ni) open_q <= 1'b0;
    else         open_q <= ~open_q;
  end

  // cs_ni high: either the closing edge of a frame or idle sclk activity
  always_ff @(posedge sclk_i or posedge cs_ni or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      upd_q   <= 1'b0;
      close_q <= 1'b0;
    end else if (cs_ni) begin
      if (open_q != close_q) begin
        close_q <= open_q;
        done_q  <= 1'b0;
        if (cnt_i == FULL) begin
          err_q <= 1'b0;
          if (!done_q) begin
            cfg_q <= word_i;
            upd_q <= ~upd_q;
          end
        end else begin
          err_q <= 1'b1;
        end
      end else begin
        err_q <= 1'b0;
      end
    end else begin
      err_q <= 1'b0;
      if (cnt_i == FULL && !done_q) begin
        cfg_q  <= word_i;
        done_q <= 1'b1;
        upd_q  <= ~upd_q;
      end
    end
  end

  assign cfg_o     = cfg_q;
  assign upd_tog_o = upd_q;
  assign err_o     = err_q;

  AST_IDLE_CNT_CLEAR: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    cs_ni |-> (cnt_i == '0)); // R5
endmodule

// File: rtl/csp_gain_sync.sv
module csp_gain_sync #(
  parameter int GAIN_W = 5,
  parameter int NUM_CH = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tog_i,
  input  logic [NUM_CH*GAIN_W-1:0] hold_i,
  output logic [NUM_CH*GAIN_W-1:0] gain_o
);
  localparam int VEC_W = NUM_CH * GAIN_W;

  logic sync1_q, sync2_q, load;
  logic [NUM_CH-1:0][GAIN_W-1:0] gain_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= tog_i;
      sync2_q <= sync1_q;
    end
  end

  // load on the second falling edge that sees the new toggle
  assign load = sync1_q ^ sync2_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   gain_q[c] <= '0;
      else if (load) gain_q[c] <= hold_i[c*GAIN_W +: GAIN_W];
    end
  end

  assign gain_o = VEC_W'(gain_q);

  AST_HOLD_STABLE_AT_LOAD: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (sync1_q ^ sync2_q) |-> $stable(hold_i)); // R9
  AST_TOGGLE_RATE: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (sync1_q != sync2_q) |=> (sync1_q == sync2_q)); // R9
  AST_GAIN_FROM_HOLD: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !$stable(gain_o) |-> (gain_o == hold_i)); // R9
endmodule

// File: rtl/ctrl_serial_port.sv
module ctrl_serial_port
  import csp_pkg::*;
#(
  parameter int WORD_W = CSP_WORD_W,
  parameter int GAIN_W = CSP_GAIN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              sdi_i,
  output logic              twos_o,
  output logic              mode_o,
  output logic              bus_sel_o,
  output logic [GAIN_W-1:0] gain_a_o,
  output logic [GAIN_W-1:0] gain_b_o,
  output logic              err_o
);
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int NUM_CH = CSP_NUM_CH;
  localparam int VEC_W  = NUM_CH * GAIN_W;

  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] word, cfg;
  logic              upd_tog;
  logic [VEC_W-1:0]  hold, gain;
  csp_flags_t        flags;
  logic              unused_rsv;

  csp_shift #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .cs_ni  (cs_ni),
    .sdi_i  (sdi_i),
    .cnt_o  (cnt),
    .word_o (word)
  );

  csp_commit #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_commit (
    .rst_ni    (rst_ni),
    .sclk_i    (sclk_i),
    .cs_ni     (cs_ni),
    .cnt_i     (cnt),
    .word_i    (word),
    .cfg_o     (cfg),
    .upd_tog_o (upd_tog),
    .err_o     (err_o)
  );

  assign flags.twos    = cfg[CSP_TWOS_POS];
  assign flags.mode    = cfg[CSP_MODE_POS];
  assign flags.bus_sel = cfg[CSP_BUS_POS];
  assign unused_rsv    = ^{cfg[WORD_W-1:CSP_TWOS_POS+1], cfg[CSP_RSV_POS]};

  // channel 0 = A, channel 1 = B
  assign hold = {cfg[CSP_GB_LSB +: GAIN_W], cfg[CSP_GA_LSB +: GAIN_W]};

  csp_gain_sync #(.GAIN_W(GAIN_W), .NUM_CH(NUM_CH)) u_gain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tog_i  (upd_tog),
    .hold_i (hold),
    .gain_o (gain)
  );

  assign twos_o    = flags.twos;
  assign mode_o    = flags.mode;
  assign bus_sel_o = flags.bus_sel;
  assign gain_a_o  = gain[GAIN_W-1:0];
  assign gain_b_o  = gain[2*GAIN_W-1:GAIN_W];
endmodule

// File: tb/tb_ctrl_serial_port.sv
module tb_ctrl_serial_port;
  logic clk_i = 1'b0, rst_ni = 1'b0, sclk_i = 1'b1, cs_ni = 1'b1, sdi_i = 1'b0;
  logic twos_o, mode_o, bus_sel_o, err_o;
  logic [4:0] gain_a_o, gain_b_o;

  int vecs = 0, errs = 0;
  logic [15:0] exp_w = '0;

  ctrl_serial_port dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .cs_ni(cs_ni), .sdi_i(sdi_i),
    .twos_o(twos_o), .mode_o(mode_o), .bus_sel_o(bus_sel_o),
    .gain_a_o(gain_a_o), .gain_b_o(gain_b_o), .err_o(err_o)
  );

  always #4 clk_i = ~clk_i;

  function automatic logic [15:0] flags_of(input logic [15:0] w);
    return {13'd0, w[13], w[12], w[11]};
  endfunction
  function automatic logic [15:0] gains_of(input logic [15:0] w);
    return {6'd0, w[9:5], w[4:0]};
  endfunction
  function automatic logic [15:0] obs_flags();
    return {13'd0, twos_o, mode_o, bus_sel_o};
  endfunction
  function automatic logic [15:0] obs_gains();
    return {6'd0, gain_b_o, gain_a_o};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  task automatic hp();
    repeat (3) @(posedge clk_i);
    #1;
  endtask

  task automatic gain_timing(input logic [15:0] oldw, input logic [15:0] neww);
    @(negedge clk_i); #1;
    chk("R7 first edge", obs_gains(), gains_of(oldw));
    @(negedge clk_i); #1;
    chk("R7 second edge", obs_gains(), gains_of(neww));
  endtask

  task automatic frame(input logic [15:0] w, input int nbits, input bit by_cs,
                       input bit timed, input string req);
    logic [15:0] prev;
    prev  = exp_w;
    cs_ni = 1'b0;
    hp();
    for (int i = 0; i < nbits; i++) begin
      sdi_i = (i < 16) ? w[15-i] : 1'($urandom_range(0, 1));
      hp();
      sclk_i = 1'b0;
      hp();
      if (by_cs && i == 15) break;
      sclk_i = 1'b1;
      #1;
      if (i == 15) begin
        exp_w = w;
        chk({req, " R3 flags"}, obs_flags(), flags_of(w));
        if (timed) gain_timing(prev, w);
      end
    end
    cs_ni = 1'b1;
    #1;
    if (nbits < 16) begin
      chk("R5 err set", {15'd0, err_o}, 16'd1);
      chk("R5 flags kept", obs_flags(), flags_of(exp_w));
      hp(); sclk_i = 1'b0; hp(); sclk_i = 1'b1; #1;
      chk("R5 err cleared", {15'd0, err_o}, 16'd0);
    end else if (by_cs) begin
      exp_w = w;
      chk({req, " R4 flags"}, obs_flags(), flags_of(w));
      chk("R4 no err", {15'd0, err_o}, 16'd0);
      if (timed) gain_timing(prev, w);
      hp();
      sclk_i = 1'b1;
    end else begin
      chk({req, " no err"}, {15'd0, err_o}, 16'd0);
    end
    repeat (4) @(posedge clk_i);
    #1;
    chk({req, " R9 gains"}, obs_gains(), gains_of(exp_w));
    chk({req, " flags"}, obs_flags(), flags_of(exp_w));
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    vecs++; errs++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 flags in reset", obs_flags(), 16'd0);
    rst_ni = 1'b1;
    repeat (2) @(posedge clk_i);
    #1;
    chk("R1 flags", obs_flags(), 16'd0);
    chk("R1 gains", obs_gains(), 16'd0);
    chk("R1 err", {15'd0, err_o}, 16'd0);

    frame(16'h2000, 16, 1'b0, 1'b0, "R2 twos");
    frame(16'h1000, 16, 1'b0, 1'b0, "R2 mode");
    frame(16'h0800, 16, 1'b0, 1'b0, "R2 bus");
    frame(16'h0001, 16, 1'b0, 1'b1, "R2 gainA");
    frame(16'h0020, 16, 1'b1, 1'b1, "R2 gainB");
    frame(16'h3bde, 16, 1'b0, 1'b1, "R3");
    frame(16'h0c63, 16, 1'b1, 1'b1, "R4");
    frame(16'hffff, 15, 1'b0, 1'b0, "R5 short15");
    frame(16'h0000, 0,  1'b0, 1'b0, "R5 empty");
    frame(16'h1234, 20, 1'b0, 1'b0, "R6 long");
    frame(16'hc400, 16, 1'b0, 1'b0, "R8 reserved");
    frame(16'hc7ff, 16, 1'b1, 1'b0, "R8 reserved cs");

    for (int n = 0; n < 150; n++) begin
      int kind;
      logic [15:0] w;
      kind = int'($urandom_range(0, 9));
      w    = 16'($urandom);
      if (kind < 2)       frame(w, int'($urandom_range(0, 15)), 1'b0, 1'b0, "R5 rnd");
      else if (kind == 2) frame(w, int'($urandom_range(17, 20)), 1'b0, 1'b0, "R6 rnd");
      else if (kind < 6)  frame(w, 16, 1'b1, kind == 3, "R4 rnd");
      else                frame(w, 16, 1'b0, kind == 6, "R3 rnd");
    end
    report();
  end
endmodule